// File: doc/BRIEF.md
# Multiplexed Bus Cycle Capture Sequencer

This block observes every cycle of a slow 8-bit microcomputer expansion bus. It has a single 8-bit input path, and three external transceivers share it. The transceivers carry the address high byte, the address low byte and the data byte. The block drives three active-low enables so that only one transceiver is on at any time. It waits a fixed number of system clocks after each switch so the path can settle, then samples it. Each bus cycle becomes one 26-bit record holding both address bytes, the read/write level, the active-low device-select level and a data byte. The record appears on the output with a one-cycle valid strobe.

The block runs on a fast system clock of roughly 125 MHz. The bus clock arrives asynchronously and passes through a two-stage synchronizer. The sequence branches on the read/write level after the address low byte has been sampled:

- On a write, the data transceiver is enabled and the data byte is sampled late, once the bus has settled.
- On a read, the status is sampled at once and the data byte in the record has no meaning.

After each record, the block waits for the bus clock to go low and then for a tail delay. It then returns to the address high byte.

Top module: `bus_snoop_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, the enables read 3'b011, `rec_valid_o` is 0 and `overflow_o` is 0. Reset is synchronous and active high.
- R2: `xcvr_en_n_o` is packed as {data, addr_lo, addr_hi}. Each bit is active low, and exactly one bit is 0 at every cycle: 3'b011 selects address high, 3'b101 address low, 3'b110 data.
- R3: The enables read 3'b011 while the block waits for the bus clock. The address high byte is sampled while 3'b011 is driven, two clocks after the synchronized bus clock is first seen high.
- R4: After the address high sample, the enables switch to 3'b101. The address low byte is sampled only after the path has been held on that setting for LO_SETTLE further clocks (default 5).
- R5: On a read (`rw_i` high when the address low byte has been sampled), the data enable never goes low for that bus cycle. `rec_valid_o` rises at the (LO_SETTLE+6)-th rising clock edge, counting from the first edge that sees `bus_clk_i` high, which gives 11 edges with defaults.
- R6: On a write (`rw_i` low), the enables switch to 3'b110 for DATA_SETTLE clocks (default 15) before status and data are sampled. `rec_valid_o` rises at the (LO_SETTLE+DATA_SETTLE+7)-th edge, which gives 27 edges with defaults.
- R7: The record is `rec_o` = {addr_hi[25:18], addr_lo[17:10], rw[9], sel_n[8], data[7:0]}.
- R8: `rec_valid_o` is high for exactly one cycle per bus cycle, and `rec_o` holds its value until the next record.
- R9: After a record, the block waits for the synchronized bus clock to be low, then for TAIL_SETTLE clocks (default 7), and then drives 3'b011 again. Consecutive bus cycles each yield one record.
- R10: `overflow_o` is set, and stays set until reset, when a synchronized rising edge of the bus clock arrives while the block is not waiting for the bus clock. That rising edge marks a bus cycle the sequence could not follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Asynchronous bus clock |
| rw_i | input | 1 | Bus read/write level, high means read |
| sel_n_i | input | 1 | Bus device select, active low |
| path_i | input | 8 | Shared transceiver output path |
| xcvr_en_n_o | output | 3 | Active-low enables {data, addr_lo, addr_hi} |
| rec_o | output | 26 | Captured cycle record |
| rec_valid_o | output | 1 | One-cycle strobe for a new record |
| overflow_o | output | 1 | Sticky flag for a missed bus cycle |

## Verification
Some properties are checked by assertions on every cycle:

- exactly one enable is active;
- each sample point occurs under the enable that belongs to it;
- a write record is produced only under the data enable and a read record without it;
- the valid strobe lasts one cycle;
- the overflow flag is sticky.

Other behaviour can only be shown by the bench's scenarios. The bench uses a transceiver model whose outputs become valid late. The scenarios show that each settle delay is long enough to read real values rather than stale ones, that the latency to the strobe is exact, that the record layout is correct, that the block returns to the address-high setting, and that an overly fast bus clock sets overflow.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [2:0] {
    ST_ARM, ST_HI, ST_LO, ST_BRANCH, ST_DATA, ST_FALL, ST_TAIL
  } seq_state_t;

  localparam logic [2:0] EN_HI   = 3'b011;
  localparam logic [2:0] EN_LO   = 3'b101;
  localparam logic [2:0] EN_DATA = 3'b110;

  // status field: read/write level, device select, data byte
  function automatic logic [9:0] pack_status(input logic rw, input logic sel_n,
                                             input logic [7:0] data);
    return {rw, sel_n, data};
  endfunction

  // enable pattern for each state; after the branch it depends on direction
  function automatic logic [2:0] enable_code(input seq_state_t st, input logic wr);
    case (st)
      ST_ARM, ST_HI:     return EN_HI;
      ST_LO, ST_BRANCH:  return EN_LO;
      ST_DATA:           return EN_DATA;
      default:           return wr ? EN_DATA : EN_LO;
    endcase
  endfunction

endpackage

// File: rtl/bus_clk_sync.sv
module bus_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/record_packer.sv
module record_packer #(
  parameter int BYTE_W = 8,
  parameter int STAT_W = BYTE_W + 2,
  parameter int REC_W  = 2 * BYTE_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_byte_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              finish_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              valid_o
);
  localparam int ACC_W = 2 * BYTE_W;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      rec_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= finish_i;
      if (shift_byte_i) acc_q <= {acc_q[ACC_W-BYTE_W-1:0], byte_i};
      if (finish_i)     rec_o <= {acc_q, status_i};
    end
  end
endmodule

// File: rtl/bus_snoop_seq.sv
module bus_snoop_seq
  import snoop_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int LO_SETTLE   = 5,
  parameter int DATA_SETTLE = 15,
  parameter int TAIL_SETTLE = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_clk_i,
  input  logic                  rw_i,
  input  logic                  sel_n_i,
  input  logic [BYTE_W-1:0]     path_i,
  output logic [2:0]            xcvr_en_n_o,
  output logic [3*BYTE_W+1:0]   rec_o,
  output logic                  rec_valid_o,
  output logic                  overflow_o
);
  localparam int STAT_W  = BYTE_W + 2;
  localparam int REC_W   = 3 * BYTE_W + 2;
  localparam int MAX_DLY = (LO_SETTLE > DATA_SETTLE)
                         ? ((LO_SETTLE > TAIL_SETTLE) ? LO_SETTLE : TAIL_SETTLE)
                         : ((DATA_SETTLE > TAIL_SETTLE) ? DATA_SETTLE : TAIL_SETTLE);
  localparam int CNT_W   = $clog2(MAX_DLY + 1) < 1 ? 1 : $clog2(MAX_DLY + 1);

  seq_state_t state_q, state_d;
  logic       wr_q, wr_d;
  logic       ovf_q;

  // named internal events
  logic bus_lvl_w, rise_w;
  logic cap_hi_w, cap_lo_w, emit_w;
  logic tmr_load_w, tmr_done_w;
  logic [CNT_W-1:0] tmr_val_w;
  logic in_arm_w;

  bus_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(bus_clk_i),
    .level_o(bus_lvl_w), .rise_o(rise_w)
  );

  settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load_w),
    .load_val_i(tmr_val_w), .done_o(tmr_done_w)
  );

  record_packer #(.BYTE_W(BYTE_W), .STAT_W(STAT_W), .REC_W(REC_W)) u_pack (
    .clk(clk), .rst(rst),
    .shift_byte_i(cap_hi_w | cap_lo_w), .byte_i(path_i),
    .finish_i(emit_w),
    .status_i({rw_i, sel_n_i, path_i}),
    .rec_o(rec_o), .valid_o(rec_valid_o)
  );

  always_comb begin
    state_d    = state_q;
    wr_d       = wr_q;
    cap_hi_w   = 1'b0;
    cap_lo_w   = 1'b0;
    emit_w     = 1'b0;
    tmr_load_w = 1'b0;
    tmr_val_w  = '0;
    case (state_q)
      ST_ARM: if (bus_lvl_w) state_d = ST_HI;
      ST_HI: begin
        cap_hi_w   = 1'b1;
        tmr_load_w = 1'b1;
        tmr_val_w  = CNT_W'(LO_SETTLE);
        state_d    = ST_LO;
      end
      ST_LO: if (tmr_done_w) begin
        cap_lo_w = 1'b1;
        state_d  = ST_BRANCH;
      end
      ST_BRANCH: if (rw_i) begin
        emit_w  = 1'b1;
        state_d = ST_FALL;
      end else begin
        wr_d       = 1'b1;
        tmr_load_w = 1'b1;
        tmr_val_w  = CNT_W'(DATA_SETTLE);
        state_d    = ST_DATA;
      end
      ST_DATA: if (tmr_done_w) begin
        emit_w  = 1'b1;
        state_d = ST_FALL;
      end
      ST_FALL: if (!bus_lvl_w) begin
        tmr_load_w = 1'b1;
        tmr_val_w  = CNT_W'(TAIL_SETTLE);
        state_d    = ST_TAIL;
      end
      ST_TAIL: if (tmr_done_w) begin
        wr_d    = 1'b0;
        state_d = ST_ARM;
      end
      default: state_d = ST_ARM;
    endcase
  end

  assign in_arm_w = (state_q == ST_ARM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARM;
      wr_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      if (rise_w && !in_arm_w) ovf_q <= 1'b1;
    end
  end

  assign xcvr_en_n_o = enable_code(state_q, wr_q);
  assign overflow_o  = ovf_q;

endmodule

// File: rtl/bus_snoop_chk.sv
module bus_snoop_chk
  import snoop_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        en_n,
  input logic [3*BYTE_W+1:0] rec,
  input logic              rec_valid,
  input logic              ovf,
  input logic              cap_hi,
  input logic              cap_lo,
  input logic              emit
);
  localparam int RW_BIT = BYTE_W + 1;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (en_n == EN_HI && !rec_valid && !ovf));

  p_one_enable_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~en_n) == 1);

  p_hi_sample_r3: assert property (@(posedge clk) disable iff (rst)
    cap_hi |-> en_n == EN_HI);

  p_lo_sample_r4: assert property (@(posedge clk) disable iff (rst)
    cap_lo |-> en_n == EN_LO);

  p_read_nodata_r5: assert property (@(posedge clk) disable iff (rst)
    (emit && en_n != EN_DATA) |=> (rec_valid && rec[RW_BIT]));

  p_write_data_r6: assert property (@(posedge clk) disable iff (rst)
    (emit && en_n == EN_DATA) |=> (rec_valid && !rec[RW_BIT]));

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |-> $stable(rec));

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind bus_snoop_seq bus_snoop_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .en_n(xcvr_en_n_o), .rec(rec_o),
  .rec_valid(rec_valid_o), .ovf(overflow_o),
  .cap_hi(cap_hi_w), .cap_lo(cap_lo_w), .emit(emit_w)
);

// File: tb/test_bus_snoop_seq.sv
module test_bus_snoop_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_clk = 1'b0;
  logic        rw = 1'b1;
  logic [7:0]  path;
  logic        sel_n;
  logic [2:0]  en_n;
  logic [25:0] rec;
  logic        rec_valid;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state of the bus for the current cycle
  logic [7:0] m_hi = 8'h00, m_lo = 8'h00, m_data = 8'h00;
  logic       m_sel = 1'b1;

  always #2.5 clk = ~clk;

  bus_snoop_seq i_bus_snoop_seq (
    .clk(clk), .rst(rst), .bus_clk_i(bus_clk), .rw_i(rw), .sel_n_i(sel_n),
    .path_i(path), .xcvr_en_n_o(en_n), .rec_o(rec),
    .rec_valid_o(rec_valid), .overflow_o(ovf)
  );

  // transceiver model: a newly selected low byte or data byte is stale for a while
  logic [2:0] en_prev = 3'b011;
  int         age = 0;
  always @(posedge clk) begin
    if (en_n != en_prev) age <= 0; else age <= age + 1;
    en_prev <= en_n;
  end
  wire settled_lo   = (en_n == en_prev) && (age >= 3);
  wire settled_data = (en_n == en_prev) && (age >= 10);

  always_comb begin
    case (en_n)
      3'b011:  path = m_hi;
      3'b101:  path = settled_lo ? m_lo : 8'h5A;
      3'b110:  path = settled_data ? m_data : 8'hA5;
      default: path = 8'hFF;
    endcase
    if (rw) sel_n = m_sel;
    else    sel_n = (en_n == 3'b110 && settled_data) ? m_sel : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; drives at negedges, samples at negedges
  task automatic bus_cycle(input bit is_read, input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] dat, input bit sel, input int hi_len,
                           input int lo_len);
    int exp_lat = is_read ? (5 + 6) : (5 + 15 + 7);
    int seen = 0;
    bit saw_data_en = 1'b0;
    @(negedge clk);
    m_hi = hi; m_lo = lo; m_data = dat; m_sel = sel; rw = is_read;
    check(en_n == 3'b011, "R3 idle enable", 32'(en_n), 32'h3);
    bus_clk = 1'b1;
    for (int k = 1; k <= hi_len; k++) begin
      @(negedge clk);
      if (en_n == 3'b110) saw_data_en = 1'b1;
      if (rec_valid) begin
        if (seen == 0) begin
          check(k == exp_lat, is_read ? "R5 latency" : "R6 latency", 32'(k), 32'(exp_lat));
          check(rec[25:10] == {hi, lo}, "R7 address", 32'(rec[25:10]), 32'({hi, lo}));
          check(rec[9] == is_read, "R7 rw bit", 32'(rec[9]), 32'(is_read));
          check(rec[8] == sel, "R7 sel bit", 32'(rec[8]), 32'(sel));
          if (!is_read)
            check(rec[7:0] == dat, "R6 data byte", 32'(rec[7:0]), 32'(dat));
        end
        seen++;
      end
    end
    bus_clk = 1'b0;
    for (int k = 1; k <= lo_len; k++) begin
      @(negedge clk);
      if (rec_valid) seen++;
    end
    check(seen == 1, "R8 one strobe", 32'(seen), 32'd1);
    check(saw_data_en == !is_read, is_read ? "R5 no data enable" : "R6 data enable",
          32'(saw_data_en), 32'(!is_read));
    check(rec[25:10] == {hi, lo}, "R8 record held", 32'(rec[25:10]), 32'({hi, lo}));
    check(en_n == 3'b011, "R9 back to address high", 32'(en_n), 32'h3);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(en_n == 3'b011, "R1 enables", 32'(en_n), 32'h3);
    check(rec_valid == 1'b0, "R1 valid", 32'(rec_valid), 32'h0);
    check(ovf == 1'b0, "R1 overflow", 32'(ovf), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(en_n == 3'b011, "R2 R3 wait enable", 32'(en_n), 32'h3);
  endtask

  task automatic test_read();
    bus_cycle(1'b1, 8'hC0, 8'h30, 8'h00, 1'b0, 40, 40);
  endtask

  task automatic test_write();
    bus_cycle(1'b0, 8'h12, 8'h34, 8'h9C, 1'b0, 60, 40);
    bus_cycle(1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 60, 40);
  endtask

  task automatic test_back_to_back();
    bus_cycle(1'b1, 8'hAB, 8'hCD, 8'h00, 1'b1, 40, 12);
    bus_cycle(1'b0, 8'h55, 8'hAA, 8'h3C, 1'b0, 40, 12);
    check(ovf == 1'b0, "R10 no overflow at normal rate", 32'(ovf), 32'h0);
  endtask

  task automatic test_overflow();
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); bus_clk = 1'b1;
      repeat (6) @(negedge clk);
      bus_clk = 1'b0;
      repeat (6) @(negedge clk);
    end
    check(ovf == 1'b1, "R10 overflow set", 32'(ovf), 32'h1);
    repeat (60) @(negedge clk);
    check(ovf == 1'b1, "R10 overflow sticky", 32'(ovf), 32'h1);
    test_reset();
  endtask

  initial begin
    test_reset();
    test_read();
    test_write();
    test_back_to_back();
    test_overflow();
    test_read();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule